// File: doc/BRIEF.md
# Variable Product-Term Sum-of-Products Plane

This block is the programmable logic plane of a small array logic device. It takes twelve dedicated input signals and ten feedback lines returned by the output cells, which makes twenty-two array signals. Each signal supplies two columns, its true value and its complement, so the plane has forty-four columns. Each of the 132 rows is a product term: the AND of the columns its connect mask selects. The rows are grouped into ten sums of unequal size. Ten further rows each drive one output enable, and two rows drive a global asynchronous reset and a global synchronous preset that every output cell shares.

The connect masks are held in on-block storage. A write port takes a row index, a 44-bit mask and a strobe. A read port returns the stored mask of any row. Reset erases every mask. Term and sum evaluation is purely combinational, so a change on any array signal reaches the sum, enable and global outputs without waiting for a clock edge. The output cells, pin drivers and nonvolatile programming sit outside this block.

The block has no sequencing states. Its one register structure is the mask storage, which moves from erased to programmed one row per accepted write.

Top module: `sop_plane`

## Requirements
- R1: Array signal i drives column 2i with its true value and column 2i+1 with its complement. Signals 0 to 11 are `ded_in[0..11]` and signals 12 to 21 are `fb_in[0..9]`.
- R2: A row's term is 1 exactly when every column set in its mask is 1. A row whose mask is all zero evaluates to 0.
- R3: `sum_out[k]` is the OR of a contiguous group of rows. Starting at row 0, the groups for k = 0..9 hold 8, 10, 12, 14, 16, 16, 14, 12, 10 and 8 rows, 120 rows in total.
- R4: `oe_term[k]` equals the term of row 120+k.
- R5: `areset_term` equals the term of row 130 and `spreset_term` equals the term of row 131.
- R6: When `cfg_we` is high at a rising clock edge and `cfg_row` is below 132, `cfg_mask` replaces that row's mask. `rd_mask` combinationally returns the stored mask of row `rd_row`.
- R7: A write with `cfg_row` of 132 or above changes no stored mask, and `rd_mask` reads as zero for any `rd_row` of 132 or above.
- R8: While `rst_n` is low every mask is cleared, so after reset all sums, enables and global terms read 0.
- R9: The outputs follow changes on `ded_in` and `fb_in` within the same clock cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the mask storage |
| rst_n | input | 1 | Asynchronous active-low reset that erases all masks |
| ded_in | input | 12 | Dedicated array inputs, signals 0 to 11 |
| fb_in | input | 10 | Feedback lines from the output cells, signals 12 to 21 |
| cfg_we | input | 1 | Mask write strobe |
| cfg_row | input | 8 | Row index for a write |
| cfg_mask | input | 44 | Column connect mask to write |
| rd_row | input | 8 | Row index for read-back |
| rd_mask | output | 44 | Stored mask of row `rd_row` |
| sum_out | output | 10 | Sum-of-products result per output |
| oe_term | output | 10 | Output-enable term per output |
| areset_term | output | 1 | Shared asynchronous reset term |
| spreset_term | output | 1 | Shared synchronous preset term |

## Verification
The only internal state is the mask storage. A wrong or misplaced mask bit shows at the ports in two ways: read-back of that row returns a wrong value in the same cycle, and the sum, enable or global output that owns the row takes a wrong value as soon as an input pattern makes that column decide the term. An error in the row grouping or the column ordering shows up only when a programmed row is driven true, so the stimulus writes sparse masks. A sparse mask leaves each term true for a useful share of the random input patterns, and each output is then compared with a model on every cycle.

// File: rtl/sop_pkg.sv
package sop_pkg;

    // Number of product terms feeding output k: rises by tstep from both ends toward the middle
    function automatic int unsigned terms_of(input int unsigned k, input int unsigned n_out,
                                             input int unsigned tmin, input int unsigned tstep);
        int unsigned d;
        d = (k < n_out / 2) ? k : (n_out - 1 - k);
        return tmin + tstep * d;
    endfunction

    // First row of the group that feeds output k
    function automatic int unsigned base_of(input int unsigned k, input int unsigned n_out,
                                            input int unsigned tmin, input int unsigned tstep);
        int unsigned s;
        s = 0;
        for (int unsigned j = 0; j < k; j++) s += terms_of(j, n_out, tmin, tstep);
        return s;
    endfunction

endpackage

// File: rtl/sop_col_build.sv
module sop_col_build #(
    parameter int unsigned N_DED = 12,
    parameter int unsigned N_FB  = 10,
    localparam int unsigned N_SIG = N_DED + N_FB,
    localparam int unsigned N_COL = 2 * N_SIG
) (
    input  logic [N_DED-1:0] ded_in,
    input  logic [N_FB-1:0]  fb_in,
    output logic [N_COL-1:0] cols
);
    logic [N_SIG-1:0] sig;
    assign sig = {fb_in, ded_in};

    // Even column carries the true value, odd column the complement
    for (genvar i = 0; i < N_SIG; i++) begin : g_pair
        assign cols[2*i]   = sig[i];
        assign cols[2*i+1] = ~sig[i];
    end
endmodule

// File: rtl/sop_cfg_store.sv
module sop_cfg_store #(
    parameter int unsigned N_ROW = 132,
    parameter int unsigned N_COL = 44,
    parameter int unsigned AW    = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_row,
    input  logic [N_COL-1:0]       wr_mask,
    input  logic [AW-1:0]          rd_row,
    output logic [N_COL-1:0]       rd_mask,
    output logic [N_ROW*N_COL-1:0] masks_flat
);
    localparam logic [AW-1:0] ROW_LIM = AW'(N_ROW);

    logic [N_COL-1:0] mem [N_ROW];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < int'(N_ROW); r++) mem[r] <= '0;
        end else if (wr_en && (wr_row < ROW_LIM)) begin
            mem[wr_row] <= wr_mask;
        end
    end

    assign rd_mask = (rd_row < ROW_LIM) ? mem[rd_row] : '0;

    for (genvar r = 0; r < N_ROW; r++) begin : g_flat
        assign masks_flat[r*N_COL +: N_COL] = mem[r];
    end

    // R6
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_row < ROW_LIM) |=> (rd_row != $past(wr_row)) || (rd_mask == $past(wr_mask)));

    // R7
    oob_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_row >= ROW_LIM) |-> (rd_mask == '0));
endmodule

// File: rtl/sop_term_eval.sv
module sop_term_eval #(
    parameter int unsigned N_ROW = 132,
    parameter int unsigned N_COL = 44
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_ROW*N_COL-1:0] masks_flat,
    input  logic [N_COL-1:0]       cols,
    output logic [N_ROW-1:0]       terms
);
    for (genvar r = 0; r < N_ROW; r++) begin : g_row
        logic [N_COL-1:0] m;
        assign m = masks_flat[r*N_COL +: N_COL];
        // A connected column that is low kills the term; no connection at all also gives 0
        assign terms[r] = (|m) & (&(cols | ~m));

        // R2
        empty_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (m == '0) |-> !terms[r]);
    end
endmodule

// File: rtl/sop_sum_or.sv
module sop_sum_or
    import sop_pkg::*;
#(
    parameter int unsigned N_OUT     = 10,
    parameter int unsigned MIN_TERMS = 8,
    parameter int unsigned TERM_STEP = 2,
    parameter int unsigned N_ROW     = 132
) (
    input  logic [N_ROW-1:0] terms,
    output logic [N_OUT-1:0] sum_out,
    output logic [N_OUT-1:0] oe_term,
    output logic             areset_term,
    output logic             spreset_term
);
    localparam int unsigned N_SUM = base_of(N_OUT, N_OUT, MIN_TERMS, TERM_STEP);

    for (genvar k = 0; k < N_OUT; k++) begin : g_out
        localparam int unsigned B = base_of(k, N_OUT, MIN_TERMS, TERM_STEP);
        localparam int unsigned T = terms_of(k, N_OUT, MIN_TERMS, TERM_STEP);
        assign sum_out[k] = |terms[B +: T];
        assign oe_term[k] = terms[N_SUM + k];
    end

    assign areset_term  = terms[N_SUM + N_OUT];
    assign spreset_term = terms[N_SUM + N_OUT + 1];
endmodule

// File: rtl/sop_plane.sv
module sop_plane
    import sop_pkg::*;
#(
    parameter int unsigned N_DED     = 12,
    parameter int unsigned N_FB      = 10,
    parameter int unsigned MIN_TERMS = 8,
    parameter int unsigned TERM_STEP = 2,
    localparam int unsigned N_OUT = N_FB,
    localparam int unsigned N_COL = 2 * (N_DED + N_FB),
    localparam int unsigned N_SUM = base_of(N_OUT, N_OUT, MIN_TERMS, TERM_STEP),
    localparam int unsigned N_ROW = N_SUM + N_OUT + 2,
    localparam int unsigned AW    = $clog2(N_ROW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_DED-1:0] ded_in,
    input  logic [N_FB-1:0]  fb_in,
    input  logic             cfg_we,
    input  logic [AW-1:0]    cfg_row,
    input  logic [N_COL-1:0] cfg_mask,
    input  logic [AW-1:0]    rd_row,
    output logic [N_COL-1:0] rd_mask,
    output logic [N_OUT-1:0] sum_out,
    output logic [N_OUT-1:0] oe_term,
    output logic             areset_term,
    output logic             spreset_term
);
    logic [N_COL-1:0]       cols;
    logic [N_ROW*N_COL-1:0] masks_flat;
    logic [N_ROW-1:0]       terms;

    sop_col_build #(.N_DED(N_DED), .N_FB(N_FB)) u_cols (
        .ded_in (ded_in),
        .fb_in  (fb_in),
        .cols   (cols)
    );

    sop_cfg_store #(.N_ROW(N_ROW), .N_COL(N_COL), .AW(AW)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_we),
        .wr_row     (cfg_row),
        .wr_mask    (cfg_mask),
        .rd_row     (rd_row),
        .rd_mask    (rd_mask),
        .masks_flat (masks_flat)
    );

    sop_term_eval #(.N_ROW(N_ROW), .N_COL(N_COL)) u_terms (
        .clk        (clk),
        .rst_n      (rst_n),
        .masks_flat (masks_flat),
        .cols       (cols),
        .terms      (terms)
    );

    sop_sum_or #(.N_OUT(N_OUT), .MIN_TERMS(MIN_TERMS), .TERM_STEP(TERM_STEP), .N_ROW(N_ROW)) u_sums (
        .terms        (terms),
        .sum_out      (sum_out),
        .oe_term      (oe_term),
        .areset_term  (areset_term),
        .spreset_term (spreset_term)
    );

    // R8
    erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (sum_out == '0 && oe_term == '0 && !areset_term && !spreset_term));

    // R9
    no_hidden_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(ded_in) && $stable(fb_in) && !$past(cfg_we)) |->
            ($stable(sum_out) && $stable(oe_term) && $stable(areset_term) && $stable(spreset_term)));
endmodule

// File: tb/sop_plane_tb.sv
`timescale 1ns/1ps
module sop_plane_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] ded_in = '0;
    logic [9:0]  fb_in = '0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_row = '0;
    logic [43:0] cfg_mask = '0;
    logic [7:0]  rd_row = '0;
    logic [43:0] rd_mask;
    logic [9:0]  sum_out, oe_term;
    logic        areset_term, spreset_term;

    int vectors = 0;
    int misses  = 0;

    logic [43:0] ref_mem [132];
    int sizes [10] = '{8, 10, 12, 14, 16, 16, 14, 12, 10, 8};

    always #2.5 clk = ~clk;

    sop_plane u_dut (
        .clk(clk), .rst_n(rst_n), .ded_in(ded_in), .fb_in(fb_in),
        .cfg_we(cfg_we), .cfg_row(cfg_row), .cfg_mask(cfg_mask), .rd_row(rd_row),
        .rd_mask(rd_mask), .sum_out(sum_out), .oe_term(oe_term),
        .areset_term(areset_term), .spreset_term(spreset_term)
    );

    function automatic bit col_val(int c);
        int s = c / 2;
        bit v = (s < 12) ? ded_in[s] : fb_in[s-12];
        return (c % 2 == 1) ? !v : v;
    endfunction

    function automatic bit term_of(int r);
        if (ref_mem[r] == 0) return 1'b0;
        for (int c = 0; c < 44; c++)
            if (ref_mem[r][c] && !col_val(c)) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic [9:0] exp_sums();
        logic [9:0] v = '0;
        int row = 0;
        for (int k = 0; k < 10; k++)
            for (int t = 0; t < sizes[k]; t++) begin
                if (term_of(row)) v[k] = 1'b1;
                row++;
            end
        return v;
    endfunction

    function automatic logic [9:0] exp_oes();
        logic [9:0] v;
        for (int k = 0; k < 10; k++) v[k] = term_of(120 + k);
        return v;
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R3 sums", 64'(sum_out), 64'(exp_sums()));
        chk("R4 enables", 64'(oe_term), 64'(exp_oes()));
        chk("R5 async reset term", 64'(areset_term), 64'(term_of(130)));
        chk("R5 sync preset term", 64'(spreset_term), 64'(term_of(131)));
        if (rd_row < 132) chk("R6 readback", 64'(rd_mask), 64'(ref_mem[rd_row]));
        else              chk("R7 readback out of range", 64'(rd_mask), 64'd0);
    endtask

    // One clock: model the write at the rising edge, compare at the falling edge
    task automatic step();
        @(posedge clk);
        if (!rst_n) begin
            for (int r = 0; r < 132; r++) ref_mem[r] = '0;
        end else if (cfg_we && cfg_row < 132) begin
            ref_mem[cfg_row] = cfg_mask;
        end
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(int row, logic [43:0] m);
        cfg_we = 1'b1; cfg_row = 8'(row); cfg_mask = m; rd_row = 8'(row);
        step();
        cfg_we = 1'b0;
    endtask

    function automatic logic [43:0] sparse_mask();
        logic [43:0] m = '0;
        int n = $urandom_range(0, 2);
        for (int i = 0; i < n; i++) m[$urandom_range(0, 43)] = 1'b1;
        return m;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        for (int r = 0; r < 132; r++) ref_mem[r] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R8: erased plane after reset
        ded_in = '1; fb_in = '1;
        step();
        chk("R8 sums after erase", 64'(sum_out), 64'd0);
        chk("R8 globals after erase", 64'({oe_term, areset_term, spreset_term}), 64'd0);

        // R1: row 0 connects true of signal 0; row 8 connects complement of signal 12
        wr(0, 44'd1);
        wr(8, 44'd1 << 25);
        ded_in = '0; fb_in = '0; #1;
        chk("R1 true column low", 64'(sum_out[0]), 64'd0);
        chk("R1 complement column", 64'(sum_out[1]), 64'd1);
        ded_in[0] = 1'b1; fb_in[0] = 1'b1; #1;
        // R9: same-cycle response, no clock edge in between
        chk("R9 combinational sum0", 64'(sum_out[0]), 64'd1);
        chk("R1 complement cleared", 64'(sum_out[1]), 64'd0);
        step();

        // R2: two connected columns must both be high
        wr(59, (44'd1 << 42) | (44'd1 << 7));
        fb_in[9] = 1'b1; ded_in[3] = 1'b1; #1;
        chk("R2 one column fails", 64'(sum_out[4]), 64'd0);
        ded_in[3] = 1'b0; #1;
        chk("R2 both columns met", 64'(sum_out[4]), 64'd1);
        step();

        // R3 last row of last group, R4 enables, R5 globals
        wr(119, 44'd1 << 2);
        wr(120, 44'd1 << 2);
        wr(129, 44'd1 << 3);
        wr(130, 44'd1 << 42);
        wr(131, 44'd1 << 1);
        ded_in[1] = 1'b1; ded_in[0] = 1'b0; #1;
        chk("R3 last group edge row", 64'(sum_out[9]), 64'd1);
        chk("R4 enable row 120", 64'(oe_term), 64'h001);
        chk("R5 globals", 64'({areset_term, spreset_term}), 64'b11);
        step();

        // R7: writes above the last row change nothing
        wr(132, '1);
        wr(255, '1);
        rd_row = 8'd140; step();
        chk("R7 oob read zero", 64'(rd_mask), 64'd0);

        // Random stimulus with sparse masks and the model compared every cycle
        for (int i = 0; i < 3000; i++) begin
            cfg_we   = ($urandom_range(0, 3) == 0);
            cfg_row  = ($urandom_range(0, 15) == 0) ? 8'($urandom_range(132, 255)) : 8'($urandom_range(0, 131));
            cfg_mask = sparse_mask();
            rd_row   = 8'($urandom_range(0, 140));
            ded_in   = 12'($urandom);
            fb_in    = 10'($urandom);
            step();
        end
        cfg_we = 1'b0;

        // R8: reset in the middle of use erases every row
        rst_n = 1'b0; #1;
        chk("R8 async erase", 64'({sum_out, oe_term, areset_term, spreset_term}), 64'd0);
        step();
        rst_n = 1'b1;
        for (int r = 0; r < 132; r += 13) begin
            rd_row = 8'(r); ded_in = 12'($urandom); fb_in = 10'($urandom);
            step();
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule